// File: doc/BRIEF.md
# Interlocked Frame Reply Engine

This block sits beside a serial storage link receiver and decides the handshake answer for frames whose type the host has marked as interlocked. For each such frame it watches the incoming words and the receive-error flag. It compares the running word count with the capacity of the buffer the host reserved. It then issues exactly one reply request: positive (R_OK) or negative (R_ERR).

A frame with an error, or one that overruns its buffer, is refused at once. A clean frame is either accepted on the spot, when automatic acceptance is enabled, or held while the sender keeps waiting until the host writes an accept or a reject bit. When a positive reply is given for a frame that landed in a reserved slot, a command-complete strobe is raised. Every other reply raises a discard indication instead. Frame types that are not selected pass by with no action.

Top module: `ilk_rx_responder`

## Requirements
- R1: A frame whose type code T has bit T of `cfg_type_sel` clear causes no reply, no hold and no strobe.
- R2: A frame has a reserved slot only when bit 3 of `slot_ctrl` is set in its start cycle; the other bits of `slot_ctrl` are ignored.
- R3: A frame in which `lnk_err` is seen on any cycle from its first word through its end gets a negative reply in the cycle after its end, together with `drop_frame` and without `cmd_done`.
- R4: For a frame with a reserved slot, the word that takes the count past `slot_cap_words` triggers a negative reply in the next cycle, even if the frame has not ended. Later words of that frame cause nothing. A frame of exactly `slot_cap_words` words is not an overrun.
- R5: A clean frame that arrives while automatic acceptance is off raises `hold_pending` from the cycle after its end, and no reply is issued until the host answers.
- R6: While `hold_pending` is high, a write with `host_set` bit 12 gives a positive reply in the next cycle. A write with bit 11 gives a negative reply. When both bits are written in the same cycle, the reply is negative.
- R7: Writes of `host_set` bits 11 and 12 while `hold_pending` is low have no effect, either at once or on later frames.
- R8: `host_set` bit 14 enables automatic acceptance and `host_clr` bit 14 disables it, with the clear taking priority. While enabled, a clean frame gets a positive reply in the cycle after its end, without a hold.
- R9: A clean frame without a reserved slot that gets a positive reply raises `drop_frame` and not `cmd_done`.
- R10: `cmd_done` is a one-cycle pulse that is high exactly when a positive reply is issued for a frame with a reserved slot. `drop_frame` is high with every other reply.
- R11: Each selected frame produces exactly one `rsp_valid` pulse. After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lnk_sof | input | 1 | Frame start marker |
| lnk_word_vld | input | 1 | A 32-bit data word is present this cycle |
| lnk_eof | input | 1 | Frame end marker, carried with the last word |
| lnk_type | input | TYPE_W | Frame type code, valid with `lnk_sof` |
| lnk_err | input | 1 | Receive error seen on the current frame |
| cfg_type_sel | input | 2**TYPE_W | One bit per type code; a set bit marks that type as interlocked |
| slot_ctrl | input | CTRL_W | Control field of the slot; bit 3 marks a reserved receive slot |
| slot_cap_words | input | CAP_W | Capacity of the reserved buffer in words |
| host_set | input | 16 | Host set-write pulses: bit 11 reject, bit 12 accept, bit 14 auto-accept on |
| host_clr | input | 16 | Host clear-write pulses: bit 14 auto-accept off |
| rsp_valid | output | 1 | Reply request pulse |
| rsp_ok | output | 1 | Reply kind with `rsp_valid`: 1 positive, 0 negative |
| cmd_done | output | 1 | Command completed pulse |
| drop_frame | output | 1 | Frame data not kept |
| hold_pending | output | 1 | Waiting for a host decision |

## Verification
The overrun case is the hardest one to reach from the ports. It needs a reserved slot with a small capacity and a frame that is still streaming words after the limit, so that the reply can be seen arriving before the frame end. The bench sets the capacity to two words, sends five, and records the cycle of the reply against the cycle of the third word. It also checks that the frame end that follows produces no second reply. A frame of exactly the capacity is sent as the boundary case. Stale host writes made before a frame are checked by confirming that a later clean frame still waits in hold.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RECV  = 2'd1,
      ST_HOLD  = 2'd2,
      ST_DRAIN = 2'd3
   } ilk_state_e;

   localparam int HC_W          = 16;
   localparam int CTL_RX_BIT    = 3;
   localparam int HC_REJECT_BIT = 11;
   localparam int HC_ACCEPT_BIT = 12;
   localparam int HC_AUTO_BIT   = 14;
endpackage

// File: rtl/ilk_type_filter.sv
module ilk_type_filter #(
   parameter int TYPE_W = 4
) (
   input  logic [TYPE_W-1:0]      type_code,
   input  logic [(1<<TYPE_W)-1:0] sel_mask,
   output logic                   hit
);
   localparam int N_TYPES = 1 << TYPE_W;

   logic [N_TYPES-1:0] match;

   generate
      if (TYPE_W < 1 || TYPE_W > 8) begin : g_bad_width
         $error("ilk_type_filter: TYPE_W must lie in 1..8");
      end
      for (genvar i = 0; i < N_TYPES; i++) begin : g_cmp
         assign match[i] = sel_mask[i] && (type_code == TYPE_W'(i));
      end
   endgenerate

   assign hit = |match;
endmodule

// File: rtl/ilk_len_guard.sv
module ilk_len_guard #(
   parameter int CAP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [CAP_W-1:0] cap,
   output logic             over_now
);
   localparam int CNT_W = CAP_W + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nxt;

   generate
      if (CAP_W < 1) begin : g_bad_cap
         $error("ilk_len_guard: CAP_W must be at least 1");
      end
   endgenerate

   assign cnt_nxt  = cnt + CNT_W'(1);
   assign over_now = inc && (cnt_nxt > {1'b0, cap});

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt <= '0;
      end else if (inc && !over_now) begin
         cnt <= cnt_nxt;
      end
   end

   // R4: the count held never exceeds the capacity field range
   a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !over_now && !clr) |=> (cnt <= {1'b0, {CAP_W{1'b1}}}));
endmodule

// File: rtl/ilk_auto_mode.sv
module ilk_auto_mode (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic auto_on
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         auto_on <= 1'b0;
      end else if (clr_req) begin
         auto_on <= 1'b0;
      end else if (set_req) begin
         auto_on <= 1'b1;
      end
   end

   // R8: a clear write always leaves the mode off
   a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |=> !auto_on);
   // R8: the mode only turns on after a set write
   a_r8_set_needed: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_on && !set_req) |=> !auto_on);
endmodule

// File: rtl/ilk_rx_responder.sv
module ilk_rx_responder
   import ilk_pkg::*;
#(
   parameter int TYPE_W = 4,
   parameter int CAP_W  = 8,
   parameter int CTRL_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   lnk_sof,
   input  logic                   lnk_word_vld,
   input  logic                   lnk_eof,
   input  logic [TYPE_W-1:0]      lnk_type,
   input  logic                   lnk_err,
   input  logic [(1<<TYPE_W)-1:0] cfg_type_sel,
   input  logic [CTRL_W-1:0]      slot_ctrl,
   input  logic [CAP_W-1:0]       slot_cap_words,
   input  logic [15:0]            host_set,
   input  logic [15:0]            host_clr,
   output logic                   rsp_valid,
   output logic                   rsp_ok,
   output logic                   cmd_done,
   output logic                   drop_frame,
   output logic                   hold_pending
);
   generate
      if (CTRL_W <= CTL_RX_BIT) begin : g_bad_ctrl
         $error("ilk_rx_responder: CTRL_W too narrow for the receive bit");
      end
   endgenerate

   ilk_state_e st, st_nxt;
   logic       has_slot;
   logic       bad_seen;
   logic       type_hit;
   logic       over_now;
   logic       auto_on;
   logic       start;
   logic       cnt_inc;
   logic       fire, fire_ok, fire_store;
   logic       err_now;
   logic       host_acc, host_rej;

   assign host_acc = host_set[HC_ACCEPT_BIT];
   assign host_rej = host_set[HC_REJECT_BIT];

   ilk_type_filter #(.TYPE_W(TYPE_W)) u_filter (
      .type_code (lnk_type),
      .sel_mask  (cfg_type_sel),
      .hit       (type_hit)
   );

   assign start   = (st == ST_IDLE) && lnk_sof && type_hit;
   assign cnt_inc = (st == ST_RECV) && lnk_word_vld && has_slot;

   ilk_len_guard #(.CAP_W(CAP_W)) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start),
      .inc      (cnt_inc),
      .cap      (slot_cap_words),
      .over_now (over_now)
   );

   ilk_auto_mode u_auto (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (host_set[HC_AUTO_BIT]),
      .clr_req (host_clr[HC_AUTO_BIT]),
      .auto_on (auto_on)
   );

   assign err_now = bad_seen || lnk_err;

   always_comb begin
      st_nxt     = st;
      fire       = 1'b0;
      fire_ok    = 1'b0;
      fire_store = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (start) st_nxt = ST_RECV;
         end
         ST_RECV: begin
            if (over_now) begin
               fire   = 1'b1;
               st_nxt = lnk_eof ? ST_IDLE : ST_DRAIN;
            end else if (lnk_eof) begin
               if (err_now) begin
                  fire   = 1'b1;
                  st_nxt = ST_IDLE;
               end else if (auto_on) begin
                  fire       = 1'b1;
                  fire_ok    = 1'b1;
                  fire_store = has_slot;
                  st_nxt     = ST_IDLE;
               end else begin
                  st_nxt = ST_HOLD;
               end
            end
         end
         ST_HOLD: begin
            if (host_rej) begin
               fire   = 1'b1;
               st_nxt = ST_IDLE;
            end else if (host_acc) begin
               fire       = 1'b1;
               fire_ok    = 1'b1;
               fire_store = has_slot;
               st_nxt     = ST_IDLE;
            end
         end
         ST_DRAIN: begin
            if (lnk_eof) st_nxt = ST_IDLE;
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         has_slot   <= 1'b0;
         bad_seen   <= 1'b0;
         rsp_valid  <= 1'b0;
         rsp_ok     <= 1'b0;
         cmd_done   <= 1'b0;
         drop_frame <= 1'b0;
      end else begin
         st <= st_nxt;
         if (start) begin
            has_slot <= slot_ctrl[CTL_RX_BIT];
            bad_seen <= 1'b0;
         end else if (st == ST_RECV && lnk_err) begin
            bad_seen <= 1'b1;
         end
         rsp_valid  <= fire;
         rsp_ok     <= fire && fire_ok;
         cmd_done   <= fire && fire_ok && fire_store;
         drop_frame <= fire && !(fire_ok && fire_store);
      end
   end

   assign hold_pending = (st == ST_HOLD);

   // R10: completion only rides on a positive reply
   a_r10_done_with_ok: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |-> (rsp_valid && rsp_ok));
   // R10: every reply carries exactly one of complete or discard
   a_r10_done_xor_drop: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (cmd_done ^ drop_frame));
   a_r10_quiet_no_reply: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!cmd_done && !drop_frame && !rsp_ok));
   // R11: replies never come back to back
   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R5: holding without a host write issues no reply
   a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_pending && !host_acc && !host_rej) |=> (!rsp_valid && hold_pending));
   // R6: reject dominates while holding
   a_r6_reject_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_pending && host_rej) |=> (rsp_valid && !rsp_ok));
   // R3: an error at the frame end yields a negative reply
   a_r3_err_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RECV && lnk_eof && lnk_err) |=> (rsp_valid && !rsp_ok && !cmd_done));
   // R4: an overrun word yields a negative reply next cycle
   a_r4_overrun_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RECV && over_now) |=> (rsp_valid && !rsp_ok));
endmodule

// File: tb/ilk_rx_responder_test.sv
module ilk_rx_responder_test;
   localparam int TYPE_W = 4;
   localparam int CAP_W  = 8;
   localparam int CTRL_W = 8;
   localparam logic [TYPE_W-1:0] T_ILK   = 4'd5;
   localparam logic [TYPE_W-1:0] T_PLAIN = 4'd2;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   lnk_sof = 1'b0, lnk_word_vld = 1'b0, lnk_eof = 1'b0, lnk_err = 1'b0;
   logic [TYPE_W-1:0]      lnk_type = '0;
   logic [(1<<TYPE_W)-1:0] cfg_type_sel = 16'h0020;
   logic [CTRL_W-1:0]      slot_ctrl = 8'h08;
   logic [CAP_W-1:0]       slot_cap_words = 8'd8;
   logic [15:0]            host_set = '0, host_clr = '0;
   logic rsp_valid, rsp_ok, cmd_done, drop_frame, hold_pending;

   int n_checks = 0, n_errors = 0;
   int cyc = 0;
   int n_rsp = 0;
   int last_cyc = 0;
   logic last_ok = 1'b0, last_done = 1'b0, last_drop = 1'b0;

   ilk_rx_responder #(.TYPE_W(TYPE_W), .CAP_W(CAP_W), .CTRL_W(CTRL_W)) uut (
      .clk(clk), .rst_n(rst_n), .lnk_sof(lnk_sof), .lnk_word_vld(lnk_word_vld),
      .lnk_eof(lnk_eof), .lnk_type(lnk_type), .lnk_err(lnk_err),
      .cfg_type_sel(cfg_type_sel), .slot_ctrl(slot_ctrl), .slot_cap_words(slot_cap_words),
      .host_set(host_set), .host_clr(host_clr), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
      .cmd_done(cmd_done), .drop_frame(drop_frame), .hold_pending(hold_pending));

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rsp_valid) begin
         n_rsp     <= n_rsp + 1;
         last_cyc  <= cyc;
         last_ok   <= rsp_ok;
         last_done <= cmd_done;
         last_drop <= drop_frame;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive SOF cycle then nw word cycles, the last with EOF; err_at = word index with error (-1 none)
   // returns after the negedge following the EOF edge plus one monitor update
   task automatic send_frame(input logic [TYPE_W-1:0] t, input int nw, input int err_at,
                             output int eof_drive_cyc);
      @(negedge clk);
      lnk_sof = 1'b1; lnk_type = t;
      @(negedge clk);
      lnk_sof = 1'b0;
      for (int i = 0; i < nw; i++) begin
         lnk_word_vld = 1'b1;
         lnk_eof = (i == nw - 1);
         lnk_err = (i == err_at);
         eof_drive_cyc = cyc;
         if (i < nw - 1) @(negedge clk);
      end
      @(negedge clk);
      lnk_word_vld = 1'b0; lnk_eof = 1'b0; lnk_err = 1'b0;
      @(negedge clk);
   endtask

   task automatic host_write(input int bitpos_a, input int bitpos_b);
      @(negedge clk);
      host_set = '0;
      if (bitpos_a >= 0) host_set[bitpos_a] = 1'b1;
      if (bitpos_b >= 0) host_set[bitpos_b] = 1'b1;
      @(negedge clk);
      host_set = '0;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R11 reset rsp_valid", rsp_valid, 0);
      chk("R11 reset cmd_done", cmd_done, 0);
      chk("R11 reset drop_frame", drop_frame, 0);
      chk("R11 reset hold_pending", hold_pending, 0);
   endtask

   task automatic t_unselected;
      int b = n_rsp; int c;
      send_frame(T_PLAIN, 3, -1, c);
      repeat (3) @(negedge clk);
      chk("R1 unselected no reply", n_rsp - b, 0);
      chk("R1 unselected no hold", hold_pending, 0);
   endtask

   task automatic t_hold_accept;
      int b = n_rsp; int c;
      slot_ctrl = 8'h08; slot_cap_words = 8'd8;
      send_frame(T_ILK, 4, -1, c);
      chk("R5 hold raised", hold_pending, 1);
      repeat (4) @(negedge clk);
      chk("R5 no reply while holding", n_rsp - b, 0);
      host_write(12, -1);
      chk("R6 accept one reply", n_rsp - b, 1);
      chk("R6 accept positive", last_ok, 1);
      chk("R10 accept completes", last_done, 1);
      chk("R10 accept no drop", last_drop, 0);
      chk("R5 hold released", hold_pending, 0);
   endtask

   task automatic t_hold_reject;
      int b = n_rsp; int c;
      send_frame(T_ILK, 2, -1, c);
      host_write(11, -1);
      chk("R6 reject one reply", n_rsp - b, 1);
      chk("R6 reject negative", last_ok, 0);
      chk("R10 reject drops", last_drop, 1);
      b = n_rsp;
      send_frame(T_ILK, 2, -1, c);
      host_write(11, 12);
      chk("R6 both one reply", n_rsp - b, 1);
      chk("R6 both reject wins", last_ok, 0);
      chk("R10 both no done", last_done, 0);
   endtask

   task automatic t_stale_host;
      int b = n_rsp; int c;
      host_write(12, -1);
      host_write(11, -1);
      chk("R7 idle writes no reply", n_rsp - b, 0);
      send_frame(T_ILK, 3, -1, c);
      chk("R7 later frame still holds", hold_pending, 1);
      chk("R7 later frame no reply", n_rsp - b, 0);
      host_write(12, -1);
      chk("R7 reply after real accept", n_rsp - b, 1);
   endtask

   task automatic t_rx_error;
      int b = n_rsp; int c;
      send_frame(T_ILK, 4, 1, c);
      chk("R3 error one reply", n_rsp - b, 1);
      chk("R3 error reply cycle", last_cyc, c + 1);
      chk("R3 error negative", last_ok, 0);
      chk("R3 error drop", last_drop, 1);
      chk("R3 error no done", last_done, 0);
      chk("R3 error no hold", hold_pending, 0);
   endtask

   task automatic t_overrun;
      int b = n_rsp; int w3 = 0;
      slot_cap_words = 8'd2;
      @(negedge clk);
      lnk_sof = 1'b1; lnk_type = T_ILK;
      @(negedge clk);
      lnk_sof = 1'b0;
      for (int i = 0; i < 5; i++) begin
         lnk_word_vld = 1'b1; lnk_eof = (i == 4);
         if (i == 2) w3 = cyc;
         @(negedge clk);
      end
      lnk_word_vld = 1'b0; lnk_eof = 1'b0;
      repeat (3) @(negedge clk);
      chk("R4 overrun one reply", n_rsp - b, 1);
      chk("R4 overrun early cycle", last_cyc, w3 + 1);
      chk("R4 overrun negative", last_ok, 0);
      chk("R4 overrun no hold", hold_pending, 0);
      b = n_rsp;
      slot_cap_words = 8'd3;
      send_frame(T_ILK, 3, -1, w3);
      chk("R4 exact capacity holds", hold_pending, 1);
      chk("R4 exact capacity no reply", n_rsp - b, 0);
      host_write(12, -1);
      chk("R4 exact capacity completes", last_done, 1);
      slot_cap_words = 8'd8;
   endtask

   task automatic t_auto;
      int b; int c;
      host_write(14, -1);
      b = n_rsp;
      send_frame(T_ILK, 3, -1, c);
      chk("R8 auto one reply", n_rsp - b, 1);
      chk("R8 auto reply cycle", last_cyc, c + 1);
      chk("R8 auto positive", last_ok, 1);
      chk("R8 auto no hold", hold_pending, 0);
      chk("R10 auto completes", last_done, 1);
      b = n_rsp;
      slot_ctrl = 8'hF7;
      send_frame(T_ILK, 20, -1, c);
      chk("R9 no-slot one reply", n_rsp - b, 1);
      chk("R9 no-slot positive", last_ok, 1);
      chk("R9 no-slot drop", last_drop, 1);
      chk("R2 no-slot no done", last_done, 0);
      slot_ctrl = 8'h08;
      @(negedge clk);
      host_set[14] = 1'b1; host_clr[14] = 1'b1;
      @(negedge clk);
      host_set = '0; host_clr = '0;
      b = n_rsp;
      send_frame(T_ILK, 2, -1, c);
      chk("R8 clear wins holds", hold_pending, 1);
      chk("R8 clear wins no reply", n_rsp - b, 0);
      host_write(12, -1);
      chk("R11 single reply after clear", n_rsp - b, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_unselected;
      t_hold_accept;
      t_hold_reject;
      t_stale_host;
      t_rx_error;
      t_overrun;
      t_auto;
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #200000;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule